// File: doc/BRIEF.md
# Two-Lane Converter Sample Serializer

This block takes 12-bit converter samples, widens each one to a 14-bit word by appending two zero bits below the sample, and shifts pairs of these words out over two serial lanes. All logic runs on one fast clock at seven times the sample rate. One bit leaves each lane per fast cycle. A frame lasts fourteen fast cycles and carries two consecutive samples, N followed by N+1. Alongside the lanes the block drives a bit clock that toggles on every fast cycle, so each lane bit lines up with one bit-clock edge. It also drives a frame clock at half the sample rate, high for the first half of each frame.

A static configuration selects one of three ways of placing the two words on the lanes, and the direction in which bits are sent. In whole-word placement each lane carries one complete word per frame. In interleaved placement one lane carries the even-indexed bits and the other the odd-indexed bits. In split placement one lane carries the upper half of the word and the other the lower half. The samples and the configuration are captured together at the frame boundary, so a frame never mixes two settings.

Top module: `adc_lane_serializer`

## Requirements
- R1: While `rst_n` is low, `lane0`, `lane1`, `bit_clk` and `frame_clk` are all 0.
- R2: After reset, `bit_clk` inverts on every fast clock cycle. Its first value is 1. Every rising edge of `frame_clk` comes together with a rising edge of `bit_clk`.
- R3: `frame_clk` repeats every 14 fast cycles. It is high for slots 0 to 6 of each frame and low for slots 7 to 13. Slot 0 is the first output cycle after reset.
- R4: The serial word is `{sample[11:0], 2'b00}`, so word bits 1 and 0 are always zero on the lanes.
- R5: The two samples strobed by `smp_stb` during frame k go out in frame k+1. The older one is sample N and the newer one is N+1. Frame 0 after reset carries all-zero words.
- R6: With `cfg_map` = 2'b00, and also with the unused code 2'b11, `lane0` carries the whole word of sample N over 14 slots and `lane1` carries the whole word of N+1.
- R7: With `cfg_map` = 2'b01, slots 0 to 6 carry sample N and slots 7 to 13 carry N+1. `lane0` sends the even-indexed word bits and `lane1` the odd-indexed ones.
- R8: With `cfg_map` = 2'b10, slots 0 to 6 carry sample N and slots 7 to 13 carry N+1. `lane0` sends word bits 13 to 7 and `lane1` sends word bits 6 to 0.
- R9: With `cfg_lsb_first` = 0, each lane sends its bits from the highest word index down. With 1, it sends them from the lowest index up.
- R10: `cfg_map` and `cfg_lsb_first` are captured only at the last slot of a frame. Changes during a frame have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, seven times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Marks `smp_data` as a new sample this cycle |
| smp_data | input | 12 | Parallel converter sample |
| cfg_map | input | 2 | Lane placement: 00 whole word, 01 even/odd bits, 10 upper/lower halves, 11 as 00 |
| cfg_lsb_first | input | 1 | Bit direction on the lanes: 0 highest index first, 1 lowest first |
| lane0 | output | 1 | Serial data lane 0 |
| lane1 | output | 1 | Serial data lane 1 |
| bit_clk | output | 1 | Double-data-rate bit clock, toggles each fast cycle |
| frame_clk | output | 1 | Frame marker, high during the first half of each frame |

## Verification
Samples and configuration presented during frame k are captured at the last edge of that frame and appear in frame k+1. Slot s of frame k+1 is registered at fast edge 14(k+1)+s+1, counted from reset release. The bench counts edges itself and reads each slot at the falling edge that follows. It compares the clocks on every cycle and rebuilds the two samples after slot 13 of each frame. The configuration is scrambled at slot 4 and restored at slot 11, so a capture at any point other than the boundary shows up as a miscompare.

// File: rtl/als_pkg.sv
package als_pkg;

   typedef enum logic [1:0] {
      MAP_WORD = 2'b00,
      MAP_BIT  = 2'b01,
      MAP_BYTE = 2'b10,
      MAP_RSVD = 2'b11
   } map_e;

   typedef struct packed {
      map_e map;
      logic lsb;
   } cfg_t;

endpackage

// File: rtl/als_phase_gen.sv
module als_phase_gen #(
   parameter int WORD_W = 14,
   localparam int IW    = $clog2(WORD_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [IW-1:0] ph,
   output logic          last,
   output logic          bit_clk,
   output logic          frame_clk
);
   localparam int            HALF   = WORD_W / 2;
   localparam logic [IW-1:0] HALF_I = IW'(HALF);
   localparam logic [IW-1:0] LAST_I = IW'(WORD_W - 1);

   assign last = (ph == LAST_I);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= '0;
         bit_clk   <= 1'b0;
         frame_clk <= 1'b0;
      end else begin
         ph        <= last ? '0 : ph + IW'(1);
         bit_clk   <= ~bit_clk;
         frame_clk <= (ph < HALF_I);
      end
   end
endmodule

// File: rtl/als_frame_load.sv
module als_frame_load import als_pkg::*; #(
   parameter int SMP_W   = 12,
   parameter int WORD_W  = 14,
   parameter bit PAD_LSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb,
   input  logic [SMP_W-1:0]  smp_data,
   input  cfg_t              cfg_in,
   input  logic              load,
   output logic [WORD_W-1:0] word_n,
   output logic [WORD_W-1:0] word_n1,
   output cfg_t              cfg_q
);
   localparam int PAD_W = WORD_W - SMP_W;

   logic [SMP_W-1:0]  pend_n, pend_n1;
   logic [WORD_W-1:0] pad_n, pad_n1;

   generate
      if (PAD_W == 0) begin : g_nopad
         assign pad_n  = pend_n;
         assign pad_n1 = pend_n1;
      end else if (PAD_LSB) begin : g_pad_low
         assign pad_n  = {pend_n,  {PAD_W{1'b0}}};
         assign pad_n1 = {pend_n1, {PAD_W{1'b0}}};
      end else begin : g_pad_high
         assign pad_n  = {{PAD_W{1'b0}}, pend_n};
         assign pad_n1 = {{PAD_W{1'b0}}, pend_n1};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_n  <= '0;
         pend_n1 <= '0;
      end else if (smp_stb) begin
         pend_n  <= pend_n1;
         pend_n1 <= smp_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_n  <= '0;
         word_n1 <= '0;
         cfg_q   <= '{map: MAP_WORD, lsb: 1'b0};
      end else if (load) begin
         word_n  <= pad_n;
         word_n1 <= pad_n1;
         cfg_q   <= cfg_in;
      end
   end
endmodule

// File: rtl/als_slot_mux.sv
module als_slot_mux import als_pkg::*; #(
   parameter int WORD_W = 14,
   localparam int IW    = $clog2(WORD_W)
) (
   input  logic [IW-1:0]     ph,
   input  logic [WORD_W-1:0] word_n,
   input  logic [WORD_W-1:0] word_n1,
   input  cfg_t              cfg,
   output logic              bit0,
   output logic              bit1
);
   localparam int            HALF    = WORD_W / 2;
   localparam logic [IW-1:0] HALF_I  = IW'(HALF);
   localparam logic [IW-1:0] HLAST_I = IW'(HALF - 1);
   localparam logic [IW-1:0] LAST_I  = IW'(WORD_W - 1);
   localparam logic [IW-1:0] EVTOP_I = IW'(WORD_W - 2);

   logic              hi;
   logic [IW-1:0]     j, j2, ia, ib;
   logic [WORD_W-1:0] src, src_a, src_b;

   always_comb begin
      hi  = (ph >= HALF_I);
      j   = hi ? (ph - HALF_I) : ph;
      j2  = {j[IW-2:0], 1'b0};
      src = hi ? word_n1 : word_n;
      unique case (cfg.map)
         MAP_BIT: begin
            src_a = src;
            src_b = src;
            ia    = cfg.lsb ? j2 : (EVTOP_I - j2);
            ib    = ia + IW'(1);
         end
         MAP_BYTE: begin
            src_a = src;
            src_b = src;
            ia    = cfg.lsb ? (HALF_I + j) : (LAST_I - j);
            ib    = cfg.lsb ? j : (HLAST_I - j);
         end
         default: begin
            src_a = word_n;
            src_b = word_n1;
            ia    = cfg.lsb ? ph : (LAST_I - ph);
            ib    = ia;
         end
      endcase
      bit0 = src_a[ia];
      bit1 = src_b[ib];
   end
endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer import als_pkg::*; #(
   parameter int SMP_W   = 12,
   parameter int WORD_W  = 14,
   parameter bit PAD_LSB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_stb,
   input  logic [SMP_W-1:0] smp_data,
   input  logic [1:0]       cfg_map,
   input  logic             cfg_lsb_first,
   output logic             lane0,
   output logic             lane1,
   output logic             bit_clk,
   output logic             frame_clk
);
   localparam int IW = $clog2(WORD_W);

   generate
      if ((WORD_W % 2) != 0) begin : g_bad_odd
         $error("WORD_W must be even so each lane carries half a word per sample");
      end
      if (WORD_W < SMP_W) begin : g_bad_narrow
         $error("WORD_W must not be smaller than SMP_W");
      end
      if (WORD_W < 4) begin : g_bad_small
         $error("WORD_W must be at least 4");
      end
   endgenerate

   logic [IW-1:0]     ph;
   logic              last;
   logic [WORD_W-1:0] word_n, word_n1;
   cfg_t              cfg_in, cfg_q;
   logic              nxt0, nxt1;

   assign cfg_in = '{map: map_e'(cfg_map), lsb: cfg_lsb_first};

   als_phase_gen #(.WORD_W(WORD_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph        (ph),
      .last      (last),
      .bit_clk   (bit_clk),
      .frame_clk (frame_clk)
   );

   als_frame_load #(.SMP_W(SMP_W), .WORD_W(WORD_W), .PAD_LSB(PAD_LSB)) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_stb  (smp_stb),
      .smp_data (smp_data),
      .cfg_in   (cfg_in),
      .load     (last),
      .word_n   (word_n),
      .word_n1  (word_n1),
      .cfg_q    (cfg_q)
   );

   als_slot_mux #(.WORD_W(WORD_W)) u_mux (
      .ph      (ph),
      .word_n  (word_n),
      .word_n1 (word_n1),
      .cfg     (cfg_q),
      .bit0    (nxt0),
      .bit1    (nxt1)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane0 <= 1'b0;
         lane1 <= 1'b0;
      end else begin
         lane0 <= nxt0;
         lane1 <= nxt1;
      end
   end
endmodule

// File: rtl/als_checker.sv
module als_checker #(
   parameter int WORD_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lane0,
   input logic              lane1,
   input logic              bit_clk,
   input logic              frame_clk,
   input logic [2:0]        cfg_q,
   input logic [WORD_W-1:0] word_n
);
   localparam int HALF = WORD_W / 2;

   logic       fprev, seen;
   logic [7:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fprev <= 1'b0;
         seen  <= 1'b0;
         run   <= '0;
      end else begin
         fprev <= frame_clk;
         if (frame_clk != fprev) begin
            run  <= 8'd1;
            seen <= 1'b1;
         end else begin
            run <= run + 8'd1;
         end
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!lane0 && !lane1 && !bit_clk && !frame_clk));

   p_bclk_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_clk |=> !bit_clk);

   p_bclk_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_clk |=> bit_clk);

   p_frame_on_bclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_clk) |-> $rose(bit_clk));

   p_frame_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && (frame_clk != fprev)) |-> (run == 8'(HALF)));

   p_cfg_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_q) |=> $rose(frame_clk));

   p_word_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word_n) |=> $rose(frame_clk));
endmodule

bind adc_lane_serializer als_checker #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lane0     (lane0),
   .lane1     (lane1),
   .bit_clk   (bit_clk),
   .frame_clk (frame_clk),
   .cfg_q     (cfg_q),
   .word_n    (word_n)
);

// File: tb/adc_lane_serializer_test.sv
module adc_lane_serializer_test;
   localparam int SW  = 12;
   localparam int WW  = 14;
   localparam int HW  = 7;
   localparam int NFR = 96;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          smp_stb;
   logic [SW-1:0] smp_data;
   logic [1:0]    cfg_map;
   logic          cfg_lsb_first;
   logic          lane0, lane1, bit_clk, frame_clk;

   always #2 clk = ~clk;

   adc_lane_serializer uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_stb       (smp_stb),
      .smp_data      (smp_data),
      .cfg_map       (cfg_map),
      .cfg_lsb_first (cfg_lsb_first),
      .lane0         (lane0),
      .lane1         (lane1),
      .bit_clk       (bit_clk),
      .frame_clk     (frame_clk)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   int  pn, nf, s;
   logic [WW-1:0] la, lb, wn, wn1;
   logic [SW-1:0] en, en1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] smp_val(input int i);
      case (i % 16)
         0:       return 12'hFFF;
         1:       return 12'h000;
         2:       return 12'h800;
         3:       return 12'h001;
         default: return SW'(i * 1237 + 1443);
      endcase
   endfunction

   function automatic logic [1:0] map_of(input int f);
      return ((f % 8) < 6) ? 2'((f % 8) / 2) : 2'd3;
   endfunction

   function automatic logic lsb_of(input int f);
      return (f % 2) == 1;
   endfunction

   task automatic rebuild(input logic [1:0] m, input logic lsb,
                          input logic [WW-1:0] a, input logic [WW-1:0] b,
                          output logic [WW-1:0] w0, output logic [WW-1:0] w1);
      logic [WW-1:0] w [2];
      w[0] = '0;
      w[1] = '0;
      for (int k = 0; k < WW; k++) begin
         int h = k / HW;
         int j = k % HW;
         case (m)
            2'd1: begin
               w[h][lsb ? 2*j   : WW-2-2*j] = a[k];
               w[h][lsb ? 2*j+1 : WW-1-2*j] = b[k];
            end
            2'd2: begin
               w[h][lsb ? HW+j : WW-1-j] = a[k];
               w[h][lsb ? j    : HW-1-j] = b[k];
            end
            default: begin
               w[0][lsb ? k : WW-1-k] = a[k];
               w[1][lsb ? k : WW-1-k] = b[k];
            end
         endcase
      end
      w0 = w[0];
      w1 = w[1];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n         = 1'b0;
      smp_stb       = 1'b0;
      smp_data      = '0;
      cfg_map       = 2'd0;
      cfg_lsb_first = 1'b0;
      repeat (3) @(negedge clk);
      chk({lane0, lane1, bit_clk, frame_clk} == 4'b0, "R1", "outputs in reset",
          int'({lane0, lane1, bit_clk, frame_clk}), 0);
      rst_n = 1'b1;

      for (int e = 0; e < NFR * WW; e++) begin
         pn = e % WW;
         nf = e / WW;
         smp_stb  = (pn == 2) || (pn == 9);
         smp_data = smp_val(2 * nf + ((pn == 9) ? 1 : 0));
         // scramble mid-frame, restore before the boundary (R10)
         if (pn == 4) begin
            cfg_map       = ~map_of(nf + 1);
            cfg_lsb_first = ~lsb_of(nf + 1);
         end
         if (pn == 11) begin
            cfg_map       = map_of(nf + 1);
            cfg_lsb_first = lsb_of(nf + 1);
         end
         @(negedge clk);
         s     = pn;
         la[s] = lane0;
         lb[s] = lane1;
         chk(frame_clk == (s < HW), "R3", "frame_clk slot level",
             int'(frame_clk), int'(s < HW));
         chk(bit_clk == ((e % 2) == 0), "R2", "bit_clk phase",
             int'(bit_clk), int'((e % 2) == 0));
         if (s == WW - 1) begin
            rebuild(map_of(nf), lsb_of(nf), la, lb, wn, wn1);
            en  = (nf == 0) ? '0 : smp_val(2 * nf - 2);
            en1 = (nf == 0) ? '0 : smp_val(2 * nf - 1);
            chk({wn[1:0], wn1[1:0]} == 4'b0, "R4", "pad bits",
                int'({wn[1:0], wn1[1:0]}), 0);
            case (map_of(nf))
               2'd1: begin
                  chk(wn[WW-1:2] == en,   "R7/R9/R10/R5", "sample N",   int'(wn[WW-1:2]),  int'(en));
                  chk(wn1[WW-1:2] == en1, "R7/R9/R10/R5", "sample N+1", int'(wn1[WW-1:2]), int'(en1));
               end
               2'd2: begin
                  chk(wn[WW-1:2] == en,   "R8/R9/R10/R5", "sample N",   int'(wn[WW-1:2]),  int'(en));
                  chk(wn1[WW-1:2] == en1, "R8/R9/R10/R5", "sample N+1", int'(wn1[WW-1:2]), int'(en1));
               end
               default: begin
                  chk(wn[WW-1:2] == en,   "R6/R9/R10/R5", "sample N",   int'(wn[WW-1:2]),  int'(en));
                  chk(wn1[WW-1:2] == en1, "R6/R9/R10/R5", "sample N+1", int'(wn1[WW-1:2]), int'(en1));
               end
            endcase
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule